// File: doc/BRIEF.md
# Packed Byte Sum-of-Absolute-Differences Unit

This block is a short pipelined datapath for motion-estimation and pattern-matching style workloads. It takes two 64-bit operands, each holding eight unsigned bytes. For every byte position it forms the absolute difference between the two operands, and then it adds all eight differences into one scalar. The scalar is returned in the lowest 16-bit word of a 64-bit result. The three higher words are zero.

The caller presents both operands together with a valid strobe. Exactly two clock cycles later the result appears with its own valid strobe. There is no stall path, so a new operand pair may be accepted on every cycle. The first pipeline stage holds the eight lane differences. The second holds the reduced sum. Only the valid chain is reset.

Top module: `psad_unit`

## Requirements
- R1: Byte lane k (k = 0..7) of each operand is bits [8k+7:8k], and a lane contributes only its own byte pair to the sum.
- R2: Each lane treats both bytes as unsigned (0..255) and contributes |a - b|. For example, 0x00 against 0xFF contributes 255, not 1.
- R3: out_result[15:0] equals the sum of the eight lane differences of the accepted operand pair.
- R4: out_result[63:16] is zero whenever out_valid is high.
- R5: An input accepted with in_valid high in one cycle produces out_valid high, with its result, exactly two cycles later. Back-to-back inputs give back-to-back outputs.
- R6: Identical operands give a result of zero. One operand all 0x00 with the other all 0xFF, in either order, gives 0x00000000000007F8, which is the largest possible sum.
- R7: A synchronous active-high reset, sampled on a clock edge, forces out_valid low after that edge. out_valid stays low until a fresh input has travelled through both stages.
- R8: A cycle with in_valid low produces a cycle with out_valid low two cycles later. No output is ever produced without an input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid chain |
| in_valid | input | 1 | Operand pair is present this cycle |
| op_a | input | 64 | First operand, eight unsigned bytes |
| op_b | input | 64 | Second operand, eight unsigned bytes |
| out_valid | output | 1 | out_result holds a result this cycle |
| out_result | output | 64 | Sum in bits [15:0], upper bits zero |

## Verification
The bench drives both orderings of 0x00 against 0xFF in every lane. A design that subtracted with wraparound would return 8 instead of 2040 for one of the two orderings. A bus that differs in a single lane is walked across all eight positions, which exposes a swapped or misaligned lane slice. Identical operands must give zero, and a truncated adder tree would fail the maximum case. Random bursts with gaps and a reset taken mid-stream expose a valid chain with the wrong depth, or one that leaks a stale result across reset.

// File: rtl/psad_pkg.sv
package psad_pkg;
  localparam int unsigned PSAD_LANES  = 8;
  localparam int unsigned PSAD_LANE_W = 8;
  localparam int unsigned PSAD_RES_W  = 64;
  localparam int unsigned PSAD_SUM_W  = 16;

  // Largest reachable sum for a given lane count and lane width
  function automatic int unsigned psad_max_sum(input int unsigned lanes,
                                               input int unsigned lane_w);
    return lanes * ((32'd1 << lane_w) - 32'd1);
  endfunction
endpackage

// File: rtl/psad_lane_absdiff.sv
module psad_lane_absdiff #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] diff_o
);
  logic a_ge_b;

  // Larger minus smaller: no signed wraparound involved
  always_comb begin
    a_ge_b = (a_i >= b_i);
    diff_o = a_ge_b ? (a_i - b_i) : (b_i - a_i);
  end

  always_comb begin
    AST_LANE_ZERO_IFF_EQUAL: assert ((diff_o == '0) == (a_i == b_i)); // R2
  end
endmodule

// File: rtl/psad_sum_tree.sv
module psad_sum_tree #(
  parameter int unsigned N     = 8,
  parameter int unsigned IN_W  = 8,
  parameter int unsigned OUT_W = 11
) (
  input  logic [N*IN_W-1:0] terms_i,
  output logic [OUT_W-1:0]  sum_o
);
  logic [OUT_W-1:0] acc [N];

  // Pairwise reduction: stride 1, 2, 4 ... gives log2(N) adder levels
  always_comb begin
    for (int i = 0; i < N; i++) begin
      acc[i] = OUT_W'(terms_i[i*IN_W +: IN_W]);
    end
    for (int s = 1; s < N; s = s * 2) begin
      for (int i = 0; i < N; i = i + 2 * s) begin
        if (i + s < N) begin
          acc[i] = acc[i] + acc[i+s];
        end
      end
    end
    sum_o = acc[0];
  end
endmodule

// File: rtl/psad_unit.sv
module psad_unit
  import psad_pkg::*;
#(
  parameter int unsigned LANES  = PSAD_LANES,
  parameter int unsigned LANE_W = PSAD_LANE_W,
  parameter int unsigned RES_W  = PSAD_RES_W,
  parameter int unsigned SUM_W  = PSAD_SUM_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [LANES*LANE_W-1:0] op_a,
  input  logic [LANES*LANE_W-1:0] op_b,
  output logic                    out_valid,
  output logic [RES_W-1:0]        out_result
);
  localparam int unsigned OP_W   = LANES * LANE_W;
  localparam int unsigned TREE_W = LANE_W + $clog2(LANES);
  localparam int unsigned MAX_SUM = psad_max_sum(LANES, LANE_W);

  logic [OP_W-1:0]   diff_comb;
  logic [OP_W-1:0]   diff_q;
  logic              vld_q1;
  logic [TREE_W-1:0] sum_comb;
  logic [TREE_W-1:0] sum_q;

  // Stage 0: lane split and per-lane absolute difference
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    psad_lane_absdiff #(.W(LANE_W)) u_lane (
      .a_i    (op_a[k*LANE_W +: LANE_W]),
      .b_i    (op_b[k*LANE_W +: LANE_W]),
      .diff_o (diff_comb[k*LANE_W +: LANE_W])
    );
  end

  // Valid chain: the only reset state
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q1    <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      vld_q1    <= in_valid;
      out_valid <= vld_q1;
    end
  end

  // Data registers carry no reset
  always_ff @(posedge clk) begin
    diff_q <= diff_comb;
    sum_q  <= sum_comb;
  end

  // Stage 1: reduction tree
  psad_sum_tree #(.N(LANES), .IN_W(LANE_W), .OUT_W(TREE_W)) u_tree (
    .terms_i (diff_q),
    .sum_o   (sum_comb)
  );

  // Packing: sum in the low word, everything above cleared
  assign out_result = RES_W'(sum_q);

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid); // R5
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##1 !out_valid); // R8
  AST_RESET_FLUSH: assert property (@(posedge clk)
    rst |=> !out_valid); // R7
  AST_SUM_BOUND: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_result[SUM_W-1:0] <= SUM_W'(MAX_SUM))); // R6
  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_result[RES_W-1:SUM_W] == '0)); // R4
  AST_EQUAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_a == op_b) |=> ##1 (out_result == '0)); // R6
endmodule

// File: tb/psad_unit_bench.sv
`timescale 1ns/1ps
module psad_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        out_valid;
  logic [63:0] out_result;

  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  // history: index 0 = driven one negedge ago, 1 = two ago
  logic        h_v [2];
  logic [63:0] h_a [2];
  logic [63:0] h_b [2];
  string       h_t [2];

  always #2.5 clk = ~clk;

  psad_unit u_psad_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .out_result(out_result)
  );

  function automatic logic [63:0] ref_sad(input logic [63:0] a, input logic [63:0] b);
    int total = 0;
    for (int k = 0; k < 8; k++) begin
      int x = int'(a[k*8 +: 8]);
      int y = int'(b[k*8 +: 8]);
      total += (x > y) ? (x - y) : (y - x);
    end
    return {48'h0, 16'(total)};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic clear_hist();
    for (int i = 0; i < 2; i++) begin
      h_v[i] = 1'b0; h_a[i] = '0; h_b[i] = '0; h_t[i] = "";
    end
  endtask

  task automatic step(input logic v, input logic [63:0] a, input logic [63:0] b,
                      input string tag);
    @(negedge clk);
    check(h_v[1] ? "R5 valid" : "R8 idle", {63'h0, out_valid}, {63'h0, h_v[1]});
    if (h_v[1]) begin
      check({h_t[1], " R3 R4 result"}, out_result, ref_sad(h_a[1], h_b[1]));
    end
    h_v[1] = h_v[0]; h_a[1] = h_a[0]; h_b[1] = h_b[0]; h_t[1] = h_t[0];
    h_v[0] = v;      h_a[0] = a;      h_b[0] = b;      h_t[0] = tag;
    in_valid = v; op_a = a; op_b = b;
  endtask

  task automatic do_reset(input int cycles);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    clear_hist();
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check("R7 reset", {63'h0, out_valid}, 64'h0);
    end
    rst = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    logic [63:0] r;
    void'($urandom(32'd20240611));
    clear_hist();
    do_reset(3);
    step(1'b0, '0, '0, "R8");
    step(1'b0, '0, '0, "R8");
    // R6 max corner, both orderings; R2 unsigned direction
    step(1'b1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, "R6 R2 zero-vs-ff");
    step(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, "R6 R2 ff-vs-zero");
    // R6 identical operands
    r = {$urandom, $urandom};
    step(1'b1, r, r, "R6 equal");
    step(1'b1, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, "R6 equal");
    // R1 single lane walk with distinct values per lane
    for (int k = 0; k < 8; k++) begin
      logic [63:0] b = 64'h0;
      b[k*8 +: 8] = 8'(8'h11 * (k + 1));
      step(1'b1, 64'h0, b, $sformatf("R1 lane%0d", k));
      step(1'b1, 64'h8080_8080_8080_8080, 64'h8080_8080_8080_8080 ^ (b & {8{8'h7F}}),
           $sformatf("R1 R2 lane%0d", k));
    end
    // R2 small-signed-looking pairs
    step(1'b1, 64'h7F80_017F_FE01_0080, 64'h807F_FE80_01FE_8000, "R2 mix");
    // R5 back-to-back random
    for (int i = 0; i < 600; i++) begin
      step(1'b1, {$urandom, $urandom}, {$urandom, $urandom}, "R5 burst");
    end
    // R8 random gaps
    for (int i = 0; i < 600; i++) begin
      step(($urandom % 3) != 0, {$urandom, $urandom}, {$urandom, $urandom}, "R8 gaps");
    end
    // R7 reset taken mid-stream
    step(1'b1, {$urandom, $urandom}, 64'h0, "R7 pre");
    step(1'b1, {$urandom, $urandom}, 64'h0, "R7 pre");
    do_reset(2);
    step(1'b0, '0, '0, "R7 post");
    step(1'b1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, "R7 R6 post");
    for (int i = 0; i < 4; i++) step(1'b0, '0, '0, "R8 drain");
    summary();
  end
endmodule